// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply and divide engine that sits beside a 32-bit integer datapath. It owns a 64-bit result pair made of two 32-bit registers, HI (upper word) and LO (lower word). A caller presents two operands and an operation code, pulses `start`, and watches `busy` and `done`. Multiplies can overwrite the pair or accumulate into it and subtract from it. Divides leave the quotient in LO and the remainder in HI. HI and LO can also be loaded and read directly. A separate `res` output carries words that go back to a general register: a copied HI or LO, or the low word of a three-operand multiply.

Multiplies, accumulates and moves finish in one clock. A divide runs through a radix-2 iterative divider and holds `busy` high until its result is written. While the unit is busy it ignores any new request. `busy` is the only interlock.

Top module: `hilo_muldiv`

## Requirements
- R1: Op 0 (load HI) copies `a` into HI and op 1 (load LO) copies `a` into LO, leaving the other register unchanged. Op 2 (read HI) and op 3 (read LO) copy the register onto `res` and change neither HI nor LO.
- R2: Op 4 forms the signed 64-bit product of `a` and `b` and writes its upper word to HI and its lower word to LO.
- R3: Op 5 does the same as op 4 with both operands treated as unsigned.
- R4: Op 6 (signed) and op 7 (unsigned) add the 64-bit product to the 64-bit value {HI,LO}, modulo 2^64.
- R5: Op 8 (signed) and op 9 (unsigned) subtract the 64-bit product from {HI,LO}, modulo 2^64.
- R6: Op 10 (signed) and op 11 (unsigned) divide `a` by `b`, writing the quotient to LO and the remainder to HI. Signed quotients truncate toward zero, and a signed remainder takes the sign of the dividend.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0, with no other effect.
- R8: A divide whose divisor is zero still completes with a `done` pulse and leaves HI and LO unchanged.
- R9: Op 12 writes the low word of the signed product to `res` and changes neither HI nor LO.
- R10: An accepted non-divide op raises `done` for the cycle after the accepting edge and never raises `busy`. An accepted divide raises `busy` for exactly 33 cycles (data width + 1). `done` goes high in the cycle in which `busy` falls, and HI/LO already hold the result in that cycle. `done` is never high while `busy` is.
- R11: A `start` seen while `busy` is high has no effect: HI, LO and `res` are unchanged and no extra `done` pulse appears. A `start` in the first cycle after `busy` falls is accepted.
- R12: A synchronous active-high `rst` clears HI, LO and `res` to zero and drops `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request an operation this cycle |
| op | input | 4 | Operation code (see requirements) |
| a | input | 32 | First operand / dividend / move source |
| b | input | 32 | Second operand / divisor |
| busy | output | 1 | Divide in progress; requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |
| res | output | 32 | General-register result word |

## Verification
The collision that matters is a new request meeting the end of a divide. The divider's final write to HI and LO falls in the same cycle as the caller's next `start`. The bench holds `start` high with a load-LO request from the cycle after a divide is accepted until one cycle past the fall of `busy`. It then checks three things: in the first idle cycle HI and LO show the divide result, the load lands one cycle later, and HI keeps the remainder. A separate single-cycle request, pulsed while the divide is still running, must leave the divide result intact and add no `done` pulse.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        OP_LDHI   = 4'd0,
        OP_LDLO   = 4'd1,
        OP_RDHI   = 4'd2,
        OP_RDLO   = 4'd3,
        OP_MULS   = 4'd4,
        OP_MULU   = 4'd5,
        OP_MACS   = 4'd6,
        OP_MACU   = 4'd7,
        OP_MSBS   = 4'd8,
        OP_MSBU   = 4'd9,
        OP_DIVS   = 4'd10,
        OP_DIVU   = 4'd11,
        OP_MULLOW = 4'd12
    } hilo_op_e;

    typedef enum logic [2:0] {
        K_LDHI,
        K_LDLO,
        K_RDHI,
        K_RDLO,
        K_MULACC,
        K_MULLOW,
        K_DIV,
        K_NOP
    } op_kind_e;

    typedef enum logic [1:0] {
        ACC_SET,
        ACC_ADD,
        ACC_SUB
    } acc_mode_e;

    typedef struct packed {
        op_kind_e  kind;
        logic      sgn;
        acc_mode_e acc;
    } op_ctl_t;

    function automatic op_ctl_t decode_op(input logic [3:0] code);
        op_ctl_t c;
        c.kind = K_NOP;
        c.sgn  = 1'b0;
        c.acc  = ACC_SET;
        case (hilo_op_e'(code))
            OP_LDHI:   c.kind = K_LDHI;
            OP_LDLO:   c.kind = K_LDLO;
            OP_RDHI:   c.kind = K_RDHI;
            OP_RDLO:   c.kind = K_RDLO;
            OP_MULS:   begin c.kind = K_MULACC; c.sgn = 1'b1; end
            OP_MULU:   c.kind = K_MULACC;
            OP_MACS:   begin c.kind = K_MULACC; c.sgn = 1'b1; c.acc = ACC_ADD; end
            OP_MACU:   begin c.kind = K_MULACC; c.acc = ACC_ADD; end
            OP_MSBS:   begin c.kind = K_MULACC; c.sgn = 1'b1; c.acc = ACC_SUB; end
            OP_MSBU:   begin c.kind = K_MULACC; c.acc = ACC_SUB; end
            OP_DIVS:   begin c.kind = K_DIV; c.sgn = 1'b1; end
            OP_DIVU:   c.kind = K_DIV;
            OP_MULLOW: begin c.kind = K_MULLOW; c.sgn = 1'b1; end
            default:   c.kind = K_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hilo_mul.sv
module hilo_mul #(
    parameter int W = hilo_pkg::DATA_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    output logic [2*W-1:0] prod
);
    localparam int XW = 2 * W + 2;

    logic signed [XW-1:0] ea;
    logic signed [XW-1:0] eb;
    logic signed [XW-1:0] full;

    always_comb begin
        ea   = {{(W + 2){sgn & a[W-1]}}, a};
        eb   = {{(W + 2){sgn & b[W-1]}}, b};
        full = ea * eb;
        prod = full[2*W-1:0];
    end
endmodule

// File: rtl/hilo_acc.sv
module hilo_acc
    import hilo_pkg::*;
#(
    parameter int W = hilo_pkg::DATA_W
) (
    input  logic [2*W-1:0] pair,
    input  logic [2*W-1:0] prod,
    input  acc_mode_e      mode,
    output logic [2*W-1:0] next_pair
);
    always_comb begin
        case (mode)
            ACC_ADD: next_pair = pair + prod;
            ACC_SUB: next_pair = pair - prod;
            default: next_pair = prod;
        endcase
    end
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
    parameter int W = hilo_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         sgn,
    output logic         running,
    output logic         fin,
    output logic         dzero,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  part;
    logic [W-1:0]  qbits;
    logic [W-1:0]  dmag;
    logic          neg_q;
    logic          neg_r;

    logic          sa;
    logic          sb;
    logic [W-1:0]  amag;
    logic [W-1:0]  bmag;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    always_comb begin
        sa      = sgn & dividend[W-1];
        sb      = sgn & divisor[W-1];
        amag    = sa ? (~dividend + 1'b1) : dividend;
        bmag    = sb ? (~divisor + 1'b1) : divisor;
        shifted = {part, qbits[W-1]};
        trial   = shifted - {1'b0, dmag};
        quo     = neg_q ? (~qbits + 1'b1) : qbits;
        rem     = neg_r ? (~part + 1'b1) : part;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            part    <= '0;
            qbits   <= '0;
            dmag    <= '0;
            neg_q   <= 1'b0;
            neg_r   <= 1'b0;
            running <= 1'b0;
            fin     <= 1'b0;
            dzero   <= 1'b0;
        end else if (go && !running) begin
            cnt     <= CW'(W);
            part    <= '0;
            qbits   <= amag;
            dmag    <= bmag;
            neg_q   <= sa ^ sb;
            neg_r   <= sa;
            dzero   <= (divisor == '0);
            running <= 1'b1;
            fin     <= 1'b0;
        end else if (running) begin
            if (!trial[W]) begin
                part  <= trial[W-1:0];
                qbits <= {qbits[W-2:0], 1'b1};
            end else begin
                part  <= shifted[W-1:0];
                qbits <= {qbits[W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                running <= 1'b0;
                fin     <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    // R6: the iteration counter stays inside its window while running
    p_cnt_window_r6: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt != '0) && (cnt <= CW'(W)));

    // R10: the finish strobe lasts a single cycle
    p_fin_single_r10: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin);

    // R10: finishing ends the run
    p_fin_idle_r10: assert property (@(posedge clk) disable iff (rst)
        fin |-> !running);
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import hilo_pkg::*;
#(
    parameter int W = hilo_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo,
    output logic [W-1:0] res
);
    localparam int PW = 2 * W;

    op_ctl_t       ctl;
    logic          accept;
    logic          div_go;
    logic [PW-1:0] prod;
    logic [PW-1:0] acc_next;
    logic          div_run;
    logic          div_fin;
    logic          div_dz;
    logic [W-1:0]  div_q;
    logic [W-1:0]  div_r;

    logic          busy_q;
    logic          done_q;
    logic [W-1:0]  hi_q;
    logic [W-1:0]  lo_q;
    logic [W-1:0]  res_q;

    always_comb begin
        ctl    = decode_op(op);
        accept = start && !busy_q;
        div_go = accept && (ctl.kind == K_DIV);
    end

    hilo_mul #(.W(W)) u_mul (
        .a    (a),
        .b    (b),
        .sgn  (ctl.sgn),
        .prod (prod)
    );

    hilo_acc #(.W(W)) u_acc (
        .pair      ({hi_q, lo_q}),
        .prod      (prod),
        .mode      (ctl.acc),
        .next_pair (acc_next)
    );

    hilo_div #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (a),
        .divisor  (b),
        .sgn      (ctl.sgn),
        .running  (div_run),
        .fin      (div_fin),
        .dzero    (div_dz),
        .quo      (div_q),
        .rem      (div_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (div_fin) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
        end else if (accept) begin
            busy_q <= (ctl.kind == K_DIV);
            done_q <= (ctl.kind != K_DIV);
        end else begin
            done_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            lo_q  <= '0;
            res_q <= '0;
        end else if (div_fin) begin
            if (!div_dz) begin
                hi_q <= div_r;
                lo_q <= div_q;
            end
        end else if (accept) begin
            case (ctl.kind)
                K_LDHI:   hi_q <= a;
                K_LDLO:   lo_q <= a;
                K_RDHI:   res_q <= hi_q;
                K_RDLO:   res_q <= lo_q;
                K_MULACC: {hi_q, lo_q} <= acc_next;
                K_MULLOW: res_q <= prod[W-1:0];
                default:  ;
            endcase
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign hi   = hi_q;
    assign lo   = lo_q;
    assign res  = res_q;

    // R10: no completion pulse while a divide is outstanding
    p_no_done_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R10: an accepted divide makes the unit busy next cycle
    p_div_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ctl.kind == K_DIV) |=> busy);

    // R10: the divider is running whenever busy is high except the write cycle
    p_busy_run_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !div_fin) |-> div_run);

    // R11: a request during a divide leaves the result registers alone
    p_ignore_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !div_fin) |=> $stable(hi) && $stable(lo) && $stable(res) && !done);

    // R8: a zero divisor completes without touching HI or LO
    p_divzero_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (div_fin && div_dz) |=> $stable(hi) && $stable(lo) && done);

    // R9: the low-word multiply leaves HI and LO alone
    p_mullow_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ctl.kind == K_MULLOW) |=> $stable(hi) && $stable(lo));

    // R1: loading HI copies the operand and keeps LO
    p_ldhi_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ctl.kind == K_LDHI) |=> (hi == $past(a)) && $stable(lo));
endmodule

// File: tb/hilo_muldiv_bench.sv
`timescale 1ns/1ps
module hilo_muldiv_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        busy;
    logic        done;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [31:0] res;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hilo_muldiv u_hilo_muldiv (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (op),
        .a     (a),
        .b     (b),
        .busy  (busy),
        .done  (done),
        .hi    (hi),
        .lo    (lo),
        .res   (res)
    );

    // {op, a, b, expected hi, expected lo, expected res}
    localparam int NV = 26;
    localparam logic [163:0] VEC [NV] = '{
        {4'd0,  32'h12345678, 32'h00000000, 32'h12345678, 32'h00000000, 32'h00000000}, // R1
        {4'd1,  32'h9ABCDEF0, 32'h00000000, 32'h12345678, 32'h9ABCDEF0, 32'h00000000}, // R1
        {4'd2,  32'h00000000, 32'h00000000, 32'h12345678, 32'h9ABCDEF0, 32'h12345678}, // R1
        {4'd3,  32'h00000000, 32'h00000000, 32'h12345678, 32'h9ABCDEF0, 32'h9ABCDEF0}, // R1
        {4'd4,  32'hFFFFFFFD, 32'h00000007, 32'hFFFFFFFF, 32'hFFFFFFEB, 32'h9ABCDEF0}, // R2
        {4'd5,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001, 32'h9ABCDEF0}, // R3
        {4'd4,  32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000, 32'h9ABCDEF0}, // R2
        {4'd0,  32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h9ABCDEF0}, // R1
        {4'd1,  32'h0000000A, 32'h00000000, 32'h00000000, 32'h0000000A, 32'h9ABCDEF0}, // R1
        {4'd6,  32'hFFFFFFFE, 32'h00000003, 32'h00000000, 32'h00000004, 32'h9ABCDEF0}, // R4
        {4'd6,  32'hFFFFFFFE, 32'h00000003, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h9ABCDEF0}, // R4
        {4'd7,  32'h00000001, 32'h00000002, 32'h00000000, 32'h00000000, 32'h9ABCDEF0}, // R4
        {4'd7,  32'hFFFFFFFF, 32'h00000002, 32'h00000001, 32'hFFFFFFFE, 32'h9ABCDEF0}, // R4
        {4'd8,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFD, 32'h9ABCDEF0}, // R5
        {4'd9,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'hFFFFFFFE, 32'h9ABCDEF0}, // R5
        {4'd8,  32'h00000002, 32'h80000000, 32'h00000001, 32'hFFFFFFFE, 32'h9ABCDEF0}, // R5
        {4'd12, 32'h00010000, 32'h00010003, 32'h00000001, 32'hFFFFFFFE, 32'h00030000}, // R9
        {4'd10, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD, 32'h00030000}, // R6
        {4'd10, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD, 32'h00030000}, // R6
        {4'd11, 32'hFFFFFFF9, 32'h00000002, 32'h00000001, 32'h7FFFFFFC, 32'h00030000}, // R6
        {4'd10, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 32'h00030000}, // R7
        {4'd11, 32'h00000100, 32'h00000000, 32'h00000000, 32'h80000000, 32'h00030000}, // R8
        {4'd10, 32'h00000005, 32'h00000000, 32'h00000000, 32'h80000000, 32'h00030000}, // R8
        {4'd11, 32'h80000000, 32'h80000001, 32'h80000000, 32'h00000000, 32'h00030000}, // R6
        {4'd3,  32'h00000000, 32'h00000000, 32'h80000000, 32'h00000000, 32'h00000000}, // R1
        {4'd2,  32'h00000000, 32'h00000000, 32'h80000000, 32'h00000000, 32'h80000000}  // R1
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    // Issue one op; returns at the negedge where the result should be visible.
    task automatic run_op(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                          output int busy_cycles);
        busy_cycles = 0;
        @(negedge clk);
        op = o; a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && busy_cycles < 100) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        start = 1'b0; op = '0; a = '0; b = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check("R12 hi", hi, 32'h0);
        check("R12 lo", lo, 32'h0);
        check("R12 res", res, 32'h0);
        check("R12 busy", {31'h0, busy}, 32'h0);
        check("R12 done", {31'h0, done}, 32'h0);

        // Table walk: R1..R9 values, R10 timing
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  vo;
            logic [31:0] va, vb, ehi, elo, eres;
            int bc;
            {vo, va, vb, ehi, elo, eres} = VEC[i];
            run_op(vo, va, vb, bc);
            if (vo == 4'd10 || vo == 4'd11)
                check($sformatf("R10 div busy cycles row %0d", i), bc, 33);
            else
                check($sformatf("R10 no busy row %0d", i), bc, 0);
            check($sformatf("R10 done row %0d", i), {31'h0, done}, 32'h1);
            check($sformatf("R2-9 hi row %0d", i), hi, ehi);
            check($sformatf("R2-9 lo row %0d", i), lo, elo);
            check($sformatf("R1 R9 res row %0d", i), res, eres);
            @(negedge clk);
            check($sformatf("R10 done drops row %0d", i), {31'h0, done}, 32'h0);
        end

        // R11: pulse a load-HI while a divide runs; it must be dropped
        begin
            int n = 0;
            @(negedge clk);
            op = 4'd11; a = 32'd100; b = 32'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            op = 4'd0; a = 32'hDEAD0000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R11 no done after ignored start", {31'h0, done}, 32'h0);
            check("R11 hi untouched mid-divide", hi, 32'h80000000);
            while (busy && n < 100) begin n++; @(negedge clk); end
            check("R11 hi = remainder", hi, 32'd2);
            check("R11 lo = quotient", lo, 32'd14);
            check("R11 res untouched", res, 32'h80000000);
        end

        // R11/R10: load-LO held through the end of a signed divide
        begin
            int n = 0;
            @(negedge clk);
            op = 4'd10; a = 32'hFFFFFFF7; b = 32'd4; start = 1'b1;
            @(negedge clk);
            op = 4'd1; a = 32'h00000055; b = 32'd0;
            while (busy && n < 100) begin n++; @(negedge clk); end
            check("R10 divide busy length", n, 33);
            check("R6 quotient before queued load", lo, 32'hFFFFFFFE);
            check("R6 remainder before queued load", hi, 32'hFFFFFFFF);
            @(negedge clk);
            start = 1'b0;
            check("R11 load accepted after busy", lo, 32'h00000055);
            check("R11 hi keeps remainder", hi, 32'hFFFFFFFF);
            check("R11 done for accepted load", {31'h0, done}, 32'h1);
        end

        // R12: reset after activity clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 hi after reset", hi, 32'h0);
        check("R12 lo after reset", lo, 32'h0);
        check("R12 res after reset", res, 32'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule